// File: doc/BRIEF.md
# Program Counter Sequencer with Branch and Jump Resolution

This block owns the program counter of a single-cycle 32-bit RISC core. In every cycle it looks at the instruction word fetched from the current PC and at the two register operand values read for that instruction. From these it works out the address of the next instruction to run. That address is loaded into the PC on the next rising clock edge. Instruction fetch reads the PC combinationally, so the instruction at a branch target is present in the cycle right after the branch.

The block resolves several kinds of control transfer. The conditional branches are equal, not-equal, signed greater-or-equal-zero and signed less-than-zero-with-link. It also handles an absolute jump, jump-with-link and jump through a register. The PC counts whole instructions, not bytes. Branch offsets are added as they are, without shifting. For jumps and linking branches the block raises a write request for the return register, with the register index and the return address. Any other instruction simply moves to the next word.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset loads the PC with zero at the next rising edge and holds the link write request low for as long as reset is high.
- R2: Any instruction not listed in R3 to R9, including opcode 6'b000001 with a field [20:16] value other than 5'b00001 or 5'b10000, gives next PC = PC + 1, taken low and no link write.
- R3: Opcode [31:26] = 6'b000100 with the rs operand equal to the rt operand gives next PC = PC + the sign-extension of instruction bits [15:0] (bit 15 replicated). With the operands unequal it gives PC + 1.
- R4: Opcode 6'b000101 takes the R3 target when rs differs from rt, and gives PC + 1 when they are equal.
- R5: Opcode 6'b000001 with bits [20:16] = 5'b00001 takes the R3 target when rs, read as signed two's complement, is zero or positive.
- R6: Opcode 6'b000001 with bits [20:16] = 5'b10000 takes the R3 target when rs is negative as a signed value. It requests a link write only when the branch is taken.
- R7: Opcode 6'b000010 gives next PC = {PC[31:26], instruction[25:0]}.
- R8: Opcode 6'b000011 jumps as in R7. It also requests a write of PC + 1 into register 31.
- R9: Opcode 6'b000000 with bits [5:0] = 6'b001000 gives next PC = the rs operand value.
- R10: Outside reset, the PC after each rising edge equals the next PC presented before that edge.
- R11: The taken output is high exactly for a taken conditional branch or any jump (R7, R8, R9). Whenever the link write request is high, the index is 31 and the data is PC + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word fetched at the current PC |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| pc | output | 32 | Current program counter, in words |
| next_pc | output | 32 | Address to be loaded at the next edge |
| taken | output | 1 | Control transfer in effect this cycle |
| link_we | output | 1 | Return-register write request |
| link_idx | output | 5 | Index of the register to write |
| link_data | output | 32 | Return address to write |

## Verification
The bench checks the signed zero tests at their edges: zero, 32'h7FFFFFFF, 32'h80000000 and -1. A design that compared these unsigned would branch the wrong way on the most negative values. Negative offsets and offsets that wrap past the top of the address space are used to catch a missing sign extension, which would send a backward branch far forward. A register jump to an address with high upper bits, followed by an absolute jump, checks that the top six PC bits are kept. A design that zeroed them would land in the low segment. The bench also applies a link-type instruction during reset, an untaken linking branch and unlisted selector values, since each of these must leave the link request low.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int W        = 32,
  parameter int IDXW     = 5,
  parameter int LINK_REG = 31,
  parameter int IMMW     = 16,
  parameter int TGTW     = 26
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    instr,
  input  logic [W-1:0]    rs_val,
  input  logic [W-1:0]    rt_val,
  output logic [W-1:0]    pc,
  output logic [W-1:0]    next_pc,
  output logic            taken,
  output logic            link_we,
  output logic [IDXW-1:0] link_idx,
  output logic [W-1:0]    link_data
);
  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_REGIMM  = 6'b000001;
  localparam logic [5:0] OP_JUMP    = 6'b000010;
  localparam logic [5:0] OP_JLINK   = 6'b000011;
  localparam logic [5:0] OP_BEQ     = 6'b000100;
  localparam logic [5:0] OP_BNE     = 6'b000101;
  localparam logic [4:0] SEL_GEZ    = 5'b00001;
  localparam logic [4:0] SEL_LTZL   = 5'b10000;
  localparam logic [5:0] FN_JREG    = 6'b001000;

  logic [5:0]   op, fn;
  logic [4:0]   sel;
  logic [W-1:0] offset, seq_pc, br_pc, jmp_pc;
  logic         same, rs_neg, link_req;

  assign op     = instr[W-1 -: 6];
  assign sel    = instr[20:16];
  assign fn     = instr[5:0];
  assign offset = {{(W-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
  assign seq_pc = pc + W'(1);
  assign br_pc  = pc + offset;
  assign jmp_pc = {pc[W-1:TGTW], instr[TGTW-1:0]};
  assign same   = (rs_val == rt_val);
  assign rs_neg = rs_val[W-1];

  always_comb begin
    next_pc  = seq_pc;
    taken    = 1'b0;
    link_req = 1'b0;
    case (op)
      OP_BEQ: if (same) begin
        next_pc = br_pc;
        taken   = 1'b1;
      end
      OP_BNE: if (!same) begin
        next_pc = br_pc;
        taken   = 1'b1;
      end
      OP_REGIMM: begin
        if (sel == SEL_GEZ && !rs_neg) begin
          next_pc = br_pc;
          taken   = 1'b1;
        end
        if (sel == SEL_LTZL && rs_neg) begin
          next_pc  = br_pc;
          taken    = 1'b1;
          link_req = 1'b1;
        end
      end
      OP_JUMP: begin
        next_pc = jmp_pc;
        taken   = 1'b1;
      end
      OP_JLINK: begin
        next_pc  = jmp_pc;
        taken    = 1'b1;
        link_req = 1'b1;
      end
      OP_SPECIAL: if (fn == FN_JREG) begin
        next_pc = rs_val;
        taken   = 1'b1;
      end
      default: ;
    endcase
  end

  assign link_we   = link_req && !rst;
  assign link_idx  = IDXW'(LINK_REG);
  assign link_data = seq_pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= next_pc;
  end
endmodule

module pc_sequencer_chk #(
  parameter int W        = 32,
  parameter int IDXW     = 5,
  parameter int LINK_REG = 31
) (
  input logic            clk,
  input logic            rst,
  input logic [W-1:0]    pc,
  input logic [W-1:0]    next_pc,
  input logic            taken,
  input logic            link_we,
  input logic [IDXW-1:0] link_idx,
  input logic [W-1:0]    link_data
);
  always_comb begin
    if (rst) p_no_link_in_reset_r1: assert (!link_we) else $error("link write during reset");
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0);

  p_pc_load_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == $past(next_pc));

  p_sequential_r2: assert property (@(posedge clk) disable iff (rst)
    !taken |-> next_pc == pc + W'(1));

  p_link_fields_r11: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_idx == IDXW'(LINK_REG)) && (link_data == pc + W'(1)));

  p_link_needs_taken_r6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> taken);
endmodule

bind pc_sequencer pc_sequencer_chk #(.W(W), .IDXW(IDXW), .LINK_REG(LINK_REG)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .next_pc(next_pc), .taken(taken),
  .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
);

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] pc, next_pc, link_data;
  logic        taken, link_we;
  logic [4:0]  link_idx;

  int checks = 0, fails = 0;
  logic [31:0] mpc = '0;

  always #4 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst(rst), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ib(logic [5:0] op, logic [4:0] rt, logic [15:0] imm);
    return {op, 5'd0, rt, imm};
  endfunction

  // reference: one cycle, inputs applied at negedge, outputs sampled 2 ns later
  task automatic step(string req, logic r, logic [31:0] i, logic [31:0] a, logic [31:0] b);
    logic [31:0] seq, tgt, exp_next;
    logic        tk, lk;
    logic signed [31:0] sa;
    @(negedge clk);
    rst = r; instr = i; rs_val = a; rt_val = b;
    #2;
    sa  = a;
    seq = mpc + 32'd1;
    tgt = mpc + {{16{i[15]}}, i[15:0]};
    tk = 1'b0; lk = 1'b0; exp_next = seq;
    case (i[31:26])
      6'b000100: if (a == b) begin tk = 1; exp_next = tgt; end
      6'b000101: if (a != b) begin tk = 1; exp_next = tgt; end
      6'b000001: begin
        if (i[20:16] == 5'b00001 && sa >= 0) begin tk = 1; exp_next = tgt; end
        if (i[20:16] == 5'b10000 && sa < 0) begin tk = 1; lk = 1; exp_next = tgt; end
      end
      6'b000010: begin tk = 1; exp_next = {mpc[31:26], i[25:0]}; end
      6'b000011: begin tk = 1; lk = 1; exp_next = {mpc[31:26], i[25:0]}; end
      6'b000000: if (i[5:0] == 6'b001000) begin tk = 1; exp_next = a; end
      default: ;
    endcase
    if (r) lk = 1'b0;
    chk("R10", "pc", pc, mpc);
    chk(req, "next_pc", next_pc, exp_next);
    chk(req == "R2" ? "R2" : "R11", "taken", {31'd0, taken}, {31'd0, tk});
    chk(r ? "R1" : req, "link_we", {31'd0, link_we}, {31'd0, lk});
    if (lk) begin
      chk("R11", "link_idx", {27'd0, link_idx}, 32'd31);
      chk("R8", "link_data", link_data, seq);
    end
    @(posedge clk);
    mpc = r ? 32'd0 : exp_next;
  endtask

  initial begin
    step("R1", 1, ib(6'b000011, 0, 16'h0040), 0, 0);  // R1 link blocked in reset
    step("R1", 1, 32'hFFFF_FFFF, 0, 0);
    step("R2", 0, 32'h0000_0020, 1, 2);                // R2 plain arithmetic word
    step("R3", 0, ib(6'b000100, 0, 16'h0010), 5, 5);   // R3 taken forward
    step("R3", 0, ib(6'b000100, 0, 16'h0010), 5, 6);   // R3 not taken
    step("R3", 0, ib(6'b000100, 0, 16'hFFF8), 9, 9);   // R3 backward
    step("R4", 0, ib(6'b000101, 0, 16'h0003), 1, 2);   // R4 taken
    step("R4", 0, ib(6'b000101, 0, 16'h0003), 7, 7);   // R4 not taken
    step("R5", 0, ib(6'b000001, 5'b00001, 16'h0004), 0, 0);
    step("R5", 0, ib(6'b000001, 5'b00001, 16'h0004), 32'h7FFF_FFFF, 0);
    step("R5", 0, ib(6'b000001, 5'b00001, 16'h0004), 32'h8000_0000, 0);
    step("R6", 0, ib(6'b000001, 5'b10000, 16'hFFFE), 32'hFFFF_FFFF, 0);
    step("R6", 0, ib(6'b000001, 5'b10000, 16'hFFFE), 0, 0);
    step("R6", 0, ib(6'b000001, 5'b10000, 16'h0002), 32'h8000_0000, 0);
    step("R2", 0, ib(6'b000001, 5'b00010, 16'h0004), 0, 0); // R2 unlisted selector
    step("R2", 0, ib(6'b000001, 5'b10001, 16'h0004), 32'hFFFF_FFFF, 0);
    step("R7", 0, {6'b000010, 26'h000_0100}, 0, 0);
    step("R8", 0, {6'b000011, 26'h000_0200}, 0, 0);
    step("R9", 0, {26'd0, 6'b001000}, 32'hFC00_0010, 0);
    step("R7", 0, {6'b000010, 26'h3FF_FFF0}, 0, 0);    // R7 keeps upper PC bits
    step("R8", 0, {6'b000011, 26'h000_0007}, 0, 0);
    step("R3", 0, ib(6'b000100, 0, 16'h8000), 3, 3);
    step("R9", 0, {6'd0, 20'hABCDE, 6'b001000}, 32'hFFFF_FFFF, 0);
    step("R3", 0, ib(6'b000100, 0, 16'h0004), 1, 1);   // wraps past top
    step("R2", 0, {6'b000111, 26'h155_5555}, 0, 0);
    step("R2", 0, {26'd0, 6'b001001}, 32'h1234, 0);
    step("R1", 1, ib(6'b000001, 5'b10000, 16'h0009), 32'h8000_0000, 0);
    step("R2", 0, 32'd0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule